// File: doc/BRIEF.md
# Hold-Latch Scan Chain for Two-Pattern Delay Test

This block is a parameterised scan chain in which every scan flip-flop drives the logic under test through a hold stage. For a transition-delay test, the logic under test first needs an initialising vector and then a launching vector. With an ordinary scan chain, shifting in the second vector destroys the first one at the logic inputs. So the launching vector can only be the circuit's own response, or a one-bit shift of the first vector. The hold stage here freezes the logic inputs while the chain keeps shifting. This lets the launching vector be any pattern.

Outside test, the chain is a bank of ordinary D flip-flops between `func_d` and `func_q`, with no extra cycle of latency. A test-control input `test_ctl` opens the hold stage when high and freezes it when low. A built-in sequencer runs a complete two-pattern test from two vector inputs and a mode select, in one of three modes: arbitrary second vector, launch-from-shift, or launch-from-capture. It then unloads the captured response into `seq_resp`. While the sequencer runs, it owns the chain controls.

Top module: `enhscan_chain`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `func_q` and `scan_out` are 0, `seq_busy` and `seq_done` are 0, and `seq_step` is 0.
- R2: With `scan_en`=0, `capture_en`=1 and `test_ctl`=1, `func_q` equals the `func_d` sampled at the previous rising edge (one flop of latency, none added).
- R3: With `scan_en`=1 (which overrides `capture_en`), each edge moves cell i into cell i+1 and loads `scan_in` into cell 0. `scan_out` is the last cell.
- R4: An edge with `test_ctl`=0 leaves `func_q` unchanged whatever the chain does. After an edge with `test_ctl`=1, `func_q` equals the chain contents.
- R5: With `scan_en`=0 and `capture_en`=0, the chain keeps its contents.
- R6: `seq_mode` encoding: 2'b00 arbitrary second vector, 2'b01 launch-from-shift, 2'b10 launch-from-capture, 2'b11 treated as 2'b00. Bit i of `seq_v1`/`seq_v2` is meant for cell i. The response bit i in `seq_resp` is the value captured by cell i.
- R7: In mode 2'b00, `seq_resp` equals F(`seq_v2`), where F is the logic under test. While the second vector shifts in (`seq_step`=2), `func_q` stays at `seq_v1`.
- R8: In mode 2'b01, `seq_resp` equals F({`seq_v1`[N-2:0], `seq_v2`[0]}).
- R9: In mode 2'b10, `seq_resp` equals F(F(`seq_v1`)).
- R10: After `seq_start` is sampled in idle, `seq_busy` is high for exactly 3N+2 cycles in mode 2'b00/2'b11 and 2N+2 cycles otherwise. Then `seq_done` is high for exactly one cycle with `seq_busy` low. `seq_step` codes: 0 idle, 1 first load, 2 second shift, 3 launch, 4 capture, 5 unload, 6 done.
- R11: While `seq_busy` is high, `scan_en`, `test_ctl`, `capture_en`, `scan_in` and `seq_start` have no effect on the test result or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift the chain (external control, idle only) |
| test_ctl | input | 1 | 1: hold stage passes, 0: hold stage freezes |
| capture_en | input | 1 | Load `func_d` into the chain when not shifting |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Last cell of the chain |
| func_d | input | N | Parallel data from the logic under test |
| func_q | output | N | Parallel data to the logic under test, via hold stage |
| seq_start | input | 1 | Start a sequenced two-pattern test |
| seq_mode | input | 2 | Test mode select |
| seq_v1 | input | N | Initialising vector |
| seq_v2 | input | N | Launch vector (mode 2'b00) or shift-in bit source (2'b01) |
| seq_busy | output | 1 | Sequencer owns the chain |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_step | output | 3 | Current sequencer step code |
| seq_resp | output | N | Unloaded captured response |

## Verification
The sequencer is run with vectors chosen so that the three modes give different responses for the same inputs. An all-ones first vector with an all-zeros second vector shows whether the arbitrary-vector mode really uses V2 rather than a shift or capture of V1. Mode 2'b11 confirms it falls back to the arbitrary mode, and the measured busy length separates the three-shift sequence from the two-shift ones. Directed tests drive the chain by hand: a capture with the hold frozen shows the chain moving while `func_q` does not, a shift with capture also requested shows the shift priority, and a run disturbed by every external control shows that none of them reaches the chain while the sequencer is busy.

// File: rtl/enhscan_pkg.sv
package enhscan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LOAD1   = 3'd1,
      ST_SHIFT2  = 3'd2,
      ST_LAUNCH  = 3'd3,
      ST_CAPTURE = 3'd4,
      ST_UNLOAD  = 3'd5,
      ST_DONE    = 3'd6
   } seq_state_e;

   typedef enum logic [1:0] {
      TM_ANY   = 2'd0,
      TM_SHIFT = 2'd1,
      TM_CAPT  = 2'd2
   } test_mode_e;

   function automatic test_mode_e decode_mode(input logic [1:0] m);
      case (m)
         2'b01:   return TM_SHIFT;
         2'b10:   return TM_CAPT;
         default: return TM_ANY;
      endcase
   endfunction
endpackage

// File: rtl/enhscan_cell.sv
module enhscan_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic cap_en,
   input  logic hold_open,
   input  logic scan_d,
   input  logic func_d,
   output logic q,
   output logic hq
);
   logic d_nxt;

   always_comb begin
      if (shift_en)    d_nxt = scan_d;
      else if (cap_en) d_nxt = func_d;
      else             d_nxt = q;
   end

   // hold stage loads the flop's next value, so it tracks q with no lag when open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q  <= RST_VAL;
         hq <= RST_VAL;
      end else begin
         q <= d_nxt;
         if (hold_open) hq <= d_nxt;
      end
   end
endmodule

// File: rtl/enhscan_seq.sv
module enhscan_seq
   import enhscan_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   mode,
   input  logic [N-1:0] v1,
   input  logic [N-1:0] v2,
   input  logic         chain_so,
   output logic         busy,
   output logic         done,
   output logic [2:0]   step,
   output logic         sq_shift,
   output logic         sq_cap,
   output logic         sq_open,
   output logic         sq_si,
   output logic [N-1:0] resp
);
   localparam int CNT_W = $clog2(N + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

   seq_state_e       state_q;
   test_mode_e       mode_q;
   logic [N-1:0]     sh_q;
   logic [N-1:0]     v2_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= TM_ANY;
         sh_q    <= '0;
         v2_q    <= '0;
         cnt_q   <= '0;
         resp    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               mode_q  <= decode_mode(mode);
               sh_q    <= v1;
               v2_q    <= v2;
               cnt_q   <= '0;
               state_q <= ST_LOAD1;
            end
            ST_LOAD1: begin
               sh_q  <= sh_q << 1;
               cnt_q <= cnt_q + 1'b1;
               if (last) begin
                  cnt_q <= '0;
                  if (mode_q == TM_ANY) begin
                     sh_q    <= v2_q;
                     state_q <= ST_SHIFT2;
                  end else begin
                     state_q <= ST_LAUNCH;
                  end
               end
            end
            ST_SHIFT2: begin
               sh_q  <= sh_q << 1;
               cnt_q <= cnt_q + 1'b1;
               if (last) begin
                  cnt_q   <= '0;
                  state_q <= ST_LAUNCH;
               end
            end
            ST_LAUNCH:  state_q <= ST_CAPTURE;
            ST_CAPTURE: begin
               cnt_q   <= '0;
               state_q <= ST_UNLOAD;
            end
            ST_UNLOAD: begin
               resp  <= {resp[N-2:0], chain_so};
               cnt_q <= cnt_q + 1'b1;
               if (last) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sq_shift = 1'b0;
      sq_cap   = 1'b0;
      sq_open  = 1'b0;
      sq_si    = 1'b0;
      case (state_q)
         ST_LOAD1: begin
            sq_shift = 1'b1;
            sq_open  = 1'b1;
            sq_si    = sh_q[N-1];
         end
         ST_SHIFT2: begin
            sq_shift = 1'b1;
            sq_si    = sh_q[N-1];
         end
         ST_LAUNCH: begin
            sq_open = 1'b1;
            case (mode_q)
               TM_SHIFT: begin
                  sq_shift = 1'b1;
                  sq_si    = v2_q[0];
               end
               TM_CAPT: sq_cap = 1'b1;
               default: ;
            endcase
         end
         ST_CAPTURE: sq_cap   = 1'b1;
         ST_UNLOAD:  sq_shift = 1'b1;
         default: ;
      endcase
   end

   assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done = (state_q == ST_DONE);
   assign step = state_q;
endmodule

// File: rtl/enhscan_chain.sv
module enhscan_chain #(
   parameter int N       = 8,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scan_en,
   input  logic         test_ctl,
   input  logic         capture_en,
   input  logic         scan_in,
   output logic         scan_out,
   input  logic [N-1:0] func_d,
   output logic [N-1:0] func_q,
   input  logic         seq_start,
   input  logic [1:0]   seq_mode,
   input  logic [N-1:0] seq_v1,
   input  logic [N-1:0] seq_v2,
   output logic         seq_busy,
   output logic         seq_done,
   output logic [2:0]   seq_step,
   output logic [N-1:0] seq_resp
);
   if (N < 2) begin : g_len_check
      $error("enhscan_chain: N must be at least 2");
   end

   logic         sq_shift, sq_cap, sq_open, sq_si;
   logic         sen_i, cap_i, ctl_i, si_i;
   logic [N-1:0] chain_q;

   enhscan_seq #(.N(N)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (seq_start),
      .mode     (seq_mode),
      .v1       (seq_v1),
      .v2       (seq_v2),
      .chain_so (chain_q[N-1]),
      .busy     (seq_busy),
      .done     (seq_done),
      .step     (seq_step),
      .sq_shift (sq_shift),
      .sq_cap   (sq_cap),
      .sq_open  (sq_open),
      .sq_si    (sq_si),
      .resp     (seq_resp)
   );

   // sequencer owns every chain control while it runs
   assign sen_i = seq_busy ? sq_shift : scan_en;
   assign cap_i = seq_busy ? sq_cap   : capture_en;
   assign ctl_i = seq_busy ? sq_open  : test_ctl;
   assign si_i  = seq_busy ? sq_si    : scan_in;

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic sd;
      if (i == 0) begin : g_head
         assign sd = si_i;
      end else begin : g_body
         assign sd = chain_q[i-1];
      end
      enhscan_cell #(.RST_VAL(RST_VAL)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .shift_en  (sen_i),
         .cap_en    (cap_i),
         .hold_open (ctl_i),
         .scan_d    (sd),
         .func_d    (func_d[i]),
         .q         (chain_q[i]),
         .hq        (func_q[i])
      );
   end

   assign scan_out = chain_q[N-1];
endmodule

// File: rtl/enhscan_chain_chk.sv
module enhscan_chain_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sen_i,
   input logic         cap_i,
   input logic         ctl_i,
   input logic         si_i,
   input logic [N-1:0] func_d,
   input logic [N-1:0] func_q,
   input logic [N-1:0] chain_q,
   input logic         seq_busy,
   input logic         seq_done
);
   // R2
   capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sen_i && cap_i) |=> (chain_q == $past(func_d)));

   // R3
   shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sen_i |=> (chain_q[0] == $past(si_i)));

   // R3
   shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sen_i |=> (chain_q[N-1:1] == $past(chain_q[N-2:0])));

   // R4
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_i |=> $stable(func_q));

   // R4
   hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i |=> (func_q == chain_q));

   // R5
   chain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sen_i && !cap_i) |=> $stable(chain_q));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !seq_busy);
endmodule

bind enhscan_chain enhscan_chain_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sen_i    (sen_i),
   .cap_i    (cap_i),
   .ctl_i    (ctl_i),
   .si_i     (si_i),
   .func_d   (func_d),
   .func_q   (func_q),
   .chain_q  (chain_q),
   .seq_busy (seq_busy),
   .seq_done (seq_done)
);

// File: tb/enhscan_chain_tb.sv
`timescale 1ns/1ps
module enhscan_chain_tb;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         scan_en = 1'b0, test_ctl = 1'b1, capture_en = 1'b1, scan_in = 1'b0;
   logic         scan_out;
   logic [N-1:0] func_d, func_q, drv_d = '0;
   logic         loop_sel = 1'b0;
   logic         seq_start = 1'b0;
   logic [1:0]   seq_mode = 2'b00;
   logic [N-1:0] seq_v1 = '0, seq_v2 = '0;
   logic         seq_busy, seq_done;
   logic [2:0]   seq_step;
   logic [N-1:0] seq_resp;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   // model of the logic under test
   function automatic logic [N-1:0] lut_f(input logic [N-1:0] x);
      return {x[N-2:0], x[N-1]} ^ 8'h5A;
   endfunction

   assign func_d = loop_sel ? lut_f(func_q) : drv_d;

   enhscan_chain #(.N(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .test_ctl(test_ctl),
      .capture_en(capture_en), .scan_in(scan_in), .scan_out(scan_out),
      .func_d(func_d), .func_q(func_q), .seq_start(seq_start),
      .seq_mode(seq_mode), .seq_v1(seq_v1), .seq_v2(seq_v2),
      .seq_busy(seq_busy), .seq_done(seq_done), .seq_step(seq_step),
      .seq_resp(seq_resp)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_resp(input logic [1:0] m,
                                             input logic [N-1:0] a,
                                             input logic [N-1:0] b);
      case (m)
         2'b01:   return lut_f({a[N-2:0], b[0]});
         2'b10:   return lut_f(lut_f(a));
         default: return lut_f(b);
      endcase
   endfunction

   function automatic int exp_len(input logic [1:0] m);
      return (m == 2'b01 || m == 2'b10) ? 2 * N + 2 : 3 * N + 2;
   endfunction

   task automatic run_seq(input logic [1:0] m, input logic [N-1:0] a,
                          input logic [N-1:0] b, input bit meddle,
                          output int cyc, output int hold_bad);
      int guard;
      @(negedge clk);
      seq_mode = m; seq_v1 = a; seq_v2 = b; seq_start = 1'b1;
      @(negedge clk);
      seq_start = 1'b0;
      cyc = 0; hold_bad = 0; guard = 0;
      while (!seq_done && guard < 400) begin
         if (seq_busy) cyc++;
         if (seq_step == 3'd2 && func_q != a) hold_bad++;
         if (meddle && cyc == 3) begin
            scan_en = 1'b1; test_ctl = 1'b0; capture_en = 1'b1; scan_in = 1'b1;
            seq_start = 1'b1; seq_mode = 2'b10; seq_v1 = ~a; seq_v2 = ~b;
         end
         if (meddle && cyc == 4) seq_start = 1'b0;
         @(negedge clk);
         guard++;
      end
      if (guard >= 400) chk(1'b0, "watchdog R10", 32'(guard), 32'd400);
   endtask

   // {mode, v1, v2}
   localparam logic [17:0] VEC [6] = '{
      {2'b00, 8'h3C, 8'hA1},
      {2'b00, 8'hFF, 8'h00},
      {2'b01, 8'h96, 8'h01},
      {2'b01, 8'h0F, 8'h00},
      {2'b10, 8'h5A, 8'h77},
      {2'b11, 8'h00, 8'hFF}
   };

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] model;
      int cyc, hb;

      // R1: reset state
      repeat (2) @(negedge clk);
      chk(func_q == '0 && scan_out == 1'b0, "R1 reset outputs", 32'(func_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!seq_busy && !seq_done && seq_step == 3'd0, "R1 sequencer idle",
          {seq_busy, seq_done, seq_step}, 0);

      // R2: normal mode, one flop of latency
      drv_d = 8'h3C;
      @(negedge clk);
      chk(func_q == 8'h3C, "R2 normal capture", 32'(func_q), 32'h3C);
      drv_d = 8'hC3;
      @(negedge clk);
      chk(func_q == 8'hC3, "R2 normal capture 2", 32'(func_q), 32'hC3);

      // R4: frozen hold, chain still captures
      test_ctl = 1'b0; drv_d = 8'hFF;
      @(negedge clk);
      chk(func_q == 8'hC3, "R4 hold freezes", 32'(func_q), 32'hC3);
      chk(scan_out == 1'b1, "R4 chain moved under hold", 32'(scan_out), 1);

      // R4/R5: reopen without capture, func_q shows the chain
      test_ctl = 1'b1; capture_en = 1'b0; drv_d = 8'h00;
      @(negedge clk);
      chk(func_q == 8'hFF, "R4 reopen shows chain", 32'(func_q), 32'hFF);
      repeat (2) @(negedge clk);
      chk(func_q == 8'hFF, "R5 chain keeps", 32'(func_q), 32'hFF);

      // R3: shift with capture also requested
      model = 8'hFF;
      capture_en = 1'b1; scan_en = 1'b1;
      for (int k = 0; k < N; k++) begin
         scan_in = 8'b1011_0010 >> k;
         model = {model[N-2:0], scan_in};
         @(negedge clk);
         chk(func_q == model && scan_out == model[N-1], "R3 shift step",
             32'(func_q), 32'(model));
      end
      scan_en = 1'b0; capture_en = 1'b0; scan_in = 1'b0;

      // R6..R10: table of sequenced tests
      loop_sel = 1'b1;
      for (int t = 0; t < 6; t++) begin
         logic [1:0] m;
         logic [N-1:0] a, b;
         {m, a, b} = VEC[t];
         run_seq(m, a, b, 1'b0, cyc, hb);
         chk(seq_resp == exp_resp(m, a, b),
             (m == 2'b01) ? "R8 shift-launch response" :
             (m == 2'b10) ? "R9 capture-launch response" : "R7 R6 any-vector response",
             32'(seq_resp), 32'(exp_resp(m, a, b)));
         chk(cyc == exp_len(m), "R10 busy length", 32'(cyc), 32'(exp_len(m)));
         if (m == 2'b00 || m == 2'b11)
            chk(hb == 0, "R7 hold during second shift", 32'(hb), 0);
         @(negedge clk);
         chk(!seq_done && seq_step == 3'd0, "R10 done one cycle",
             {seq_done, seq_step}, 0);
      end

      // R11: external controls and restart ignored while busy
      run_seq(2'b00, 8'h69, 8'hC5, 1'b1, cyc, hb);
      chk(seq_resp == lut_f(8'hC5), "R11 result ignores externals",
          32'(seq_resp), 32'(lut_f(8'hC5)));
      chk(cyc == 3 * N + 2, "R11 length ignores restart", 32'(cyc), 32'(3 * N + 2));
      scan_en = 1'b0; test_ctl = 1'b1; capture_en = 1'b0; scan_in = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule